// File: doc/BRIEF.md
# Parallel Disk Interface Register-Cycle Sequencer

This block is the host end of a parallel ATA register transfer. An internal client hands it one request at a time over a valid/ready pair: direction, register address, write data and a timing mode number from 0 to 4. The block then runs a full bus cycle on the device lines. It places the address, waits out a setup interval and pulses the active-low read or write strobe. It then keeps the address through a recovery interval and returns a one-cycle done pulse. For a read, the pulse carries the captured data. For a cycle that was cut short, it carries an error flag.

All intervals are whole clock counts. Each count is the nanosecond minimum of the selected mode divided by the clock period and rounded up. The counts are computed at elaboration from the clock-period parameter. Recovery is stretched until setup plus strobe plus recovery reaches the mode's minimum cycle time. The device's ready line passes through a two-flop synchronizer. It can hold the strobe low past its nominal width, but only up to a fixed limit, after which the cycle is aborted.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1, both strobes are 1, `ata_data_oe_o` is 0 and `done_o` is 0.
- R2: The setup interval is 7, 5, 3, 3, 3 cycles for modes 0 to 4. It is counted from the cycle after acceptance to the last cycle before the strobe falls, with the address already valid.
- R3: With the ready input held high, the strobe stays low for 17, 13, 10, 8, 7 cycles in modes 0 to 4.
- R4: Recovery runs from the strobe rise until `req_ready_o` returns high and lasts 36, 21, 11, 7, 3 cycles in modes 0 to 4. It is the largest of the recovery minimum, the address hold and the cycle-time remainder.
- R5: If the ready input is low when sampled and rises in the clock cycle that is the k-th cycle of strobe-low, the strobe stays low for max(A, k+2) cycles, where A is the R3 count.
- R6: If the ready input never rises, the strobe is released after exactly 131 cycles and the done pulse carries `done_timeout_o`=1. Cycles that end normally report 0.
- R7: Read data returned with the done pulse equals `ata_data_i` at the clock edge where the read strobe rises. Later bus changes do not alter it.
- R8: A write cycle drives `ata_wr_n_o` only, with `ata_data_o` equal to the request data and `ata_data_oe_o`=1 from the first setup cycle to the end of recovery. A read never drives the bus and never lowers `ata_wr_n_o`. The two strobes are never low together.
- R9: `ata_data_oe_o` is never 1 while the read strobe is low, nor in the 3 cycles starting with the one in which the read strobe rises.
- R10: `ata_addr_o` equals the request address through setup, strobe and recovery.
- R11: Mode values 5, 6 and 7 give the same timing as mode 4.
- R12: `req_ready_o` is 0 from acceptance until the done cycle. Requests offered while busy neither start a cycle nor alter the one in progress. `done_o` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr_i | input | ADDR_W | Device register address |
| req_wdata_i | input | DATA_W | Data for a write cycle |
| req_mode_i | input | MODE_W | Timing mode, 0 slowest to 4 fastest |
| done_o | output | 1 | One-cycle completion pulse |
| done_rdata_o | output | DATA_W | Captured read data, valid with done_o |
| done_timeout_o | output | 1 | Ready wait limit hit, valid with done_o |
| ata_addr_o | output | ADDR_W | Device address lines |
| ata_rd_n_o | output | 1 | Active-low read strobe |
| ata_wr_n_o | output | 1 | Active-low write strobe |
| ata_data_o | output | DATA_W | Write data toward the pad |
| ata_data_oe_o | output | 1 | Pad output enable for the data bus |
| ata_data_i | input | DATA_W | Data bus from the pad |
| ata_iordy_i | input | 1 | Device ready, asynchronous |

## Verification
A phase counter left at a wrong value changes the strobe-edge timing within the same request. The setup, strobe-low and recovery lengths that the bench measures are then off by a cycle or more. A wrong latched mode or direction shows up at once as the wrong strobe toggling, or as the output enable set during a read. A stuck synchronizer or wait limit lengthens or cuts the strobe-low run, or flips the timeout flag on the very next done pulse. A mis-timed capture register returns the post-edge bus value instead of the pre-edge one.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   localparam int NUM_MODES = 5;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   // address valid before strobe
   function automatic int t_setup_ns(input int m);
      case (m)
         0: return 70;
         1: return 50;
         2: return 30;
         3: return 30;
         default: return 25;
      endcase
   endfunction

   // strobe low width, 16-bit transfers
   function automatic int t_active_ns(input int m);
      case (m)
         0: return 165;
         1: return 125;
         2: return 100;
         3: return 80;
         default: return 70;
      endcase
   endfunction

   // separate strobe-high minimum (zero where only cycle time applies)
   function automatic int t_recov_ns(input int m);
      case (m)
         3: return 70;
         4: return 25;
         default: return 0;
      endcase
   endfunction

   // address kept after strobe rise
   function automatic int t_hold_ns(input int m);
      case (m)
         0: return 20;
         1: return 15;
         default: return 10;
      endcase
   endfunction

   // whole cycle minimum
   function automatic int t_cycle_ns(input int m);
      case (m)
         0: return 600;
         1: return 383;
         2: return 240;
         3: return 180;
         default: return 120;
      endcase
   endfunction

endpackage

// File: rtl/pio_timing_table.sv
module pio_timing_table
   import pio_seq_pkg::*;
#(
   parameter int CLK_NS     = 10,
   parameter int MODE_W     = 3,
   parameter int CNT_W      = 8,
   parameter int SAMPLE_IDX = 6
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic [CNT_W-1:0]  setup_o,
   output logic [CNT_W-1:0]  active_o,
   output logic [CNT_W-1:0]  recov_o
);

   logic [CNT_W-1:0] s_tab [NUM_MODES];
   logic [CNT_W-1:0] a_tab [NUM_MODES];
   logic [CNT_W-1:0] r_tab [NUM_MODES];

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      localparam int S = ceil_div(t_setup_ns(m), CLK_NS);
      localparam int A = ceil_div(t_active_ns(m), CLK_NS);
      localparam int R = max3(ceil_div(t_recov_ns(m), CLK_NS),
                              ceil_div(t_hold_ns(m), CLK_NS),
                              ceil_div(t_cycle_ns(m), CLK_NS) - S - A);
      if (S < 1 || R < 1) begin : g_bad_zero
         $error("timing table: zero-length phase");
      end
      if (A <= SAMPLE_IDX) begin : g_bad_sample
         $error("timing table: strobe width ends before ready sample point");
      end
      if (S >= (1 << CNT_W) || A >= (1 << CNT_W) || R >= (1 << CNT_W)) begin : g_bad_width
         $error("timing table: count exceeds counter width");
      end
      assign s_tab[m] = CNT_W'(S);
      assign a_tab[m] = CNT_W'(A);
      assign r_tab[m] = CNT_W'(R);
   end

   logic [MODE_W-1:0] sel;

   always_comb begin
      sel      = (mode_i > MODE_W'(NUM_MODES - 1)) ? MODE_W'(NUM_MODES - 1) : mode_i;
      setup_o  = s_tab[sel];
      active_o = a_tab[sel];
      recov_o  = r_tab[sel];
   end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("sync: at least one stage required");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
   import pio_seq_pkg::*;
#(
   parameter int ADDR_W          = 3,
   parameter int DATA_W          = 16,
   parameter int MODE_W          = 3,
   parameter int CLK_NS          = 10,
   parameter int SYNC_STAGES     = 2,
   parameter int IORDY_SAMPLE_NS = 35,
   parameter int IORDY_MAX_NS    = 1250,
   parameter int BUS_RELEASE_NS  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [MODE_W-1:0] req_mode_i,
   output logic              done_o,
   output logic [DATA_W-1:0] done_rdata_o,
   output logic              done_timeout_o,
   output logic [ADDR_W-1:0] ata_addr_o,
   output logic              ata_rd_n_o,
   output logic              ata_wr_n_o,
   output logic [DATA_W-1:0] ata_data_o,
   output logic              ata_data_oe_o,
   input  logic [DATA_W-1:0] ata_data_i,
   input  logic              ata_iordy_i
);

   localparam int SAMPLE_IDX = ceil_div(IORDY_SAMPLE_NS, CLK_NS) + SYNC_STAGES;
   localparam int WAIT_LIMIT = SAMPLE_IDX + ceil_div(IORDY_MAX_NS, CLK_NS);
   localparam int CNT_W      = $clog2(WAIT_LIMIT + 1);
   localparam int GAP_C      = ceil_div(BUS_RELEASE_NS, CLK_NS);
   localparam int GAP_W      = $clog2(GAP_C + 1);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(WAIT_LIMIT - 1);
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_C);

   if (GAP_C < 1) begin : g_bad_gap
      $error("sequencer: bus release window must be at least one cycle");
   end
   if (MODE_W < 3) begin : g_bad_mode_w
      $error("sequencer: mode field too narrow for five modes");
   end

   // ---------------------------------------------------------------
   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [MODE_W-1:0] mode_q;
   logic              wr_q;
   logic [GAP_W-1:0]  gap_q;
   logic              to_q;
   logic              iordy_s;
   logic [CNT_W-1:0]  setup_c;
   logic [CNT_W-1:0]  active_c;
   logic [CNT_W-1:0]  recov_c;

   pio_timing_table #(
      .CLK_NS    (CLK_NS),
      .MODE_W    (MODE_W),
      .CNT_W     (CNT_W),
      .SAMPLE_IDX(SAMPLE_IDX)
   ) u_table (
      .mode_i  (mode_q),
      .setup_o (setup_c),
      .active_o(active_c),
      .recov_o (recov_c)
   );

   pio_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_iordy_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (ata_iordy_i),
      .q_o  (iordy_s)
   );

   logic bus_free;
   logic setup_end;
   logic strobe_ok;
   logic strobe_abort;
   logic recov_end;

   always_comb begin
      bus_free     = (gap_q == '0);
      setup_end    = (cnt_q >= setup_c - CNT_ONE) && (!wr_q || bus_free);
      strobe_ok    = (cnt_q >= active_c - CNT_ONE) && iordy_s;
      strobe_abort = (cnt_q == LIMIT_M1) && !iordy_s;
      recov_end    = (cnt_q == recov_c - CNT_ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q        <= PH_IDLE;
         cnt_q          <= '0;
         mode_q         <= '0;
         wr_q           <= 1'b0;
         gap_q          <= '0;
         to_q           <= 1'b0;
         ata_addr_o     <= '0;
         ata_data_o     <= '0;
         ata_rd_n_o     <= 1'b1;
         ata_wr_n_o     <= 1'b1;
         done_o         <= 1'b0;
         done_rdata_o   <= '0;
         done_timeout_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!bus_free) gap_q <= gap_q - GAP_W'(1);
         unique case (phase_q)
            PH_IDLE: begin
               if (req_valid_i) begin
                  phase_q    <= PH_SETUP;
                  cnt_q      <= '0;
                  mode_q     <= req_mode_i;
                  wr_q       <= req_write_i;
                  ata_addr_o <= req_addr_i;
                  ata_data_o <= req_wdata_i;
                  to_q       <= 1'b0;
               end
            end
            PH_SETUP: begin
               if (setup_end) begin
                  phase_q    <= PH_ACTIVE;
                  cnt_q      <= '0;
                  ata_rd_n_o <= wr_q;
                  ata_wr_n_o <= !wr_q;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            PH_ACTIVE: begin
               if (strobe_ok || strobe_abort) begin
                  phase_q    <= PH_RECOV;
                  cnt_q      <= '0;
                  ata_rd_n_o <= 1'b1;
                  ata_wr_n_o <= 1'b1;
                  to_q       <= !strobe_ok;
                  if (!wr_q) begin
                     done_rdata_o <= ata_data_i;
                     gap_q        <= GAP_LOAD;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            PH_RECOV: begin
               if (recov_end) begin
                  phase_q        <= PH_IDLE;
                  cnt_q          <= '0;
                  done_o         <= 1'b1;
                  done_timeout_o <= to_q;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign req_ready_o   = (phase_q == PH_IDLE);
   assign ata_data_oe_o = wr_q && (phase_q != PH_IDLE) && bus_free;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk
   import pio_seq_pkg::*;
#(
   parameter int ADDR_W          = 3,
   parameter int CLK_NS          = 10,
   parameter int SYNC_STAGES     = 2,
   parameter int IORDY_SAMPLE_NS = 35,
   parameter int IORDY_MAX_NS    = 1250,
   parameter int BUS_RELEASE_NS  = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              oe,
   input logic              ready,
   input logic              done,
   input logic [ADDR_W-1:0] addr
);

   localparam int LIMIT = ceil_div(IORDY_SAMPLE_NS, CLK_NS) + SYNC_STAGES
                          + ceil_div(IORDY_MAX_NS, CLK_NS);
   localparam int GAP   = ceil_div(BUS_RELEASE_NS, CLK_NS);

   int   low_run;
   int   since_rd;
   logic rd_prev;
   logic strobe_low;
   logic rd_rise;
   logic oe_blocked;

   assign strobe_low = !rd_n || !wr_n;
   assign rd_rise    = rd_n && !rd_prev;
   assign oe_blocked = !rd_n || rd_rise || (since_rd < GAP - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= 0;
         since_rd <= GAP;
         rd_prev  <= 1'b1;
      end else begin
         rd_prev  <= rd_n;
         low_run  <= strobe_low ? low_run + 1 : 0;
         if (rd_rise)          since_rd <= 0;
         else if (since_rd < GAP) since_rd <= since_rd + 1;
      end
   end

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R9
   oe_read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !oe_blocked);

   // R6
   wait_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_low |-> (low_run < LIMIT));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(addr));

endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(
   .ADDR_W         (ADDR_W),
   .CLK_NS         (CLK_NS),
   .SYNC_STAGES    (SYNC_STAGES),
   .IORDY_SAMPLE_NS(IORDY_SAMPLE_NS),
   .IORDY_MAX_NS   (IORDY_MAX_NS),
   .BUS_RELEASE_NS (BUS_RELEASE_NS)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .rd_n (ata_rd_n_o),
   .wr_n (ata_wr_n_o),
   .oe   (ata_data_oe_o),
   .ready(req_ready_o),
   .done (done_o),
   .addr (ata_addr_o)
);

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb;

   localparam int CLK_P  = 10;
   localparam int AW     = 3;
   localparam int DW     = 16;
   localparam int T_WAIT = 131;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [2:0]    req_mode = '0;
   logic          done;
   logic [DW-1:0] done_rdata;
   logic          done_to;
   logic [AW-1:0] ata_addr;
   logic          rd_n;
   logic          wr_n;
   logic [DW-1:0] ata_dout;
   logic          ata_oe;
   logic [DW-1:0] ata_din = '0;
   logic          iordy = 1'b1;

   int  tests = 0;
   int  fails = 0;
   bit  finished = 0;

   always #(CLK_P / 2) clk = ~clk;

   pio_cycle_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid),
      .req_ready_o   (req_ready),
      .req_write_i   (req_write),
      .req_addr_i    (req_addr),
      .req_wdata_i   (req_wdata),
      .req_mode_i    (req_mode),
      .done_o        (done),
      .done_rdata_o  (done_rdata),
      .done_timeout_o(done_to),
      .ata_addr_o    (ata_addr),
      .ata_rd_n_o    (rd_n),
      .ata_wr_n_o    (wr_n),
      .ata_data_o    (ata_dout),
      .ata_data_oe_o (ata_oe),
      .ata_data_i    (ata_din),
      .ata_iordy_i   (iordy)
   );

   function automatic int cdiv(input int n);
      return (n + CLK_P - 1) / CLK_P;
   endfunction

   function automatic int clampm(input int m);
      return (m > 4) ? 4 : m;
   endfunction

   function automatic int exp_s(input int m);
      int ns[5] = '{70, 50, 30, 30, 25};
      return cdiv(ns[clampm(m)]);
   endfunction

   function automatic int exp_a(input int m);
      int ns[5] = '{165, 125, 100, 80, 70};
      return cdiv(ns[clampm(m)]);
   endfunction

   function automatic int exp_r(input int m);
      int rec[5] = '{0, 0, 0, 70, 25};
      int hld[5] = '{20, 15, 10, 10, 10};
      int cyc[5] = '{600, 383, 240, 180, 120};
      int k;
      int v;
      k = clampm(m);
      v = cdiv(rec[k]);
      if (cdiv(hld[k]) > v) v = cdiv(hld[k]);
      if (cdiv(cyc[k]) - exp_s(m) - exp_a(m) > v) v = cdiv(cyc[k]) - exp_s(m) - exp_a(m);
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One full bus cycle; rel_k>0 holds ready low until the rel_k-th strobe-low cycle
   task automatic run_cycle(input bit wr, input int addr, input int data, input int mode,
                            input int rel_k, input bit never_rel, input bit poke);
      int  s_cnt = 0;
      int  a_cnt = 0;
      int  r_cnt = 0;
      bit  seen_low = 0;
      bit  addr_ok = 1;
      bit  bus_ok = 1;
      bit  got_done = 0;
      int  exp_low;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = AW'(addr);
      req_wdata = DW'(data);
      req_mode  = 3'(mode);
      ata_din   = DW'(data);
      if (rel_k > 0 || never_rel) iordy = 1'b0;
      @(negedge clk);
      for (int it = 0; it < 400; it++) begin
         if (done) begin
            got_done = 1;
            break;
         end
         if (poke && it < 3) begin
            req_valid = 1'b1;
            req_addr  = ~AW'(addr);
            req_write = ~wr;
         end else begin
            req_valid = 1'b0;
         end
         if (!req_ready) begin
            if (ata_addr != AW'(addr)) addr_ok = 0;
            if (wr) begin
               if (!ata_oe || ata_dout != DW'(data) || !rd_n) bus_ok = 0;
            end else begin
               if (ata_oe || !wr_n) bus_ok = 0;
            end
            if ((wr ? !wr_n : !rd_n)) begin
               seen_low = 1;
               a_cnt++;
               if (!never_rel && a_cnt == rel_k) iordy = 1'b1;
            end else if (!seen_low) begin
               s_cnt++;
            end else begin
               r_cnt++;
               if (!wr && r_cnt == 1) ata_din = ~DW'(data);
            end
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      iordy = 1'b1;
      exp_low = never_rel ? T_WAIT :
                (rel_k > 0 ? ((exp_a(mode) > rel_k + 2) ? exp_a(mode) : rel_k + 2) : exp_a(mode));
      chk(got_done, "R12 done pulse seen", int'(got_done), 1);
      chk(s_cnt == exp_s(mode), (mode > 4) ? "R11 R2 setup cycles" : "R2 setup cycles", s_cnt, exp_s(mode));
      if (never_rel)
         chk(a_cnt == exp_low, "R6 strobe low at timeout", a_cnt, exp_low);
      else if (rel_k > 0)
         chk(a_cnt == exp_low, "R5 strobe low with ready wait", a_cnt, exp_low);
      else
         chk(a_cnt == exp_low, (mode > 4) ? "R11 R3 strobe cycles" : "R3 strobe cycles", a_cnt, exp_low);
      chk(r_cnt == exp_r(mode), "R4 recovery cycles", r_cnt, exp_r(mode));
      chk(done_to == never_rel, "R6 timeout flag", int'(done_to), int'(never_rel));
      chk(addr_ok, "R10 address held", int'(addr_ok), 1);
      chk(bus_ok, wr ? "R8 write data drive" : "R8 R9 read leaves bus undriven", int'(bus_ok), 1);
      if (!wr && !never_rel)
         chk(done_rdata == DW'(data), "R7 read capture", int'(done_rdata), data & 16'hffff);
      if (poke) begin
         @(negedge clk);
         chk(req_ready && rd_n && wr_n, "R12 busy request ignored", int'(req_ready), 1);
         @(negedge clk);
         chk(req_ready && rd_n && wr_n, "R12 no late start", int'(req_ready), 1);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(rd_n && wr_n, "R1 strobes high in reset", int'(rd_n & wr_n), 1);
      chk(!ata_oe && !done, "R1 bus and done idle", int'(ata_oe | done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && rd_n && wr_n && !ata_oe && !done, "R1 idle after release", int'(req_ready), 1);

      for (int m = 0; m < 8; m++) begin
         for (int w = 0; w < 2; w++) begin
            run_cycle(w[0], (m * 3 + w) & 7, 16'h1357 + m * 16'h0f21 + w * 16'h4400, m, 0, 0, 0);
         end
      end

      // R5 ready wait at several release points
      run_cycle(0, 2, 16'hA5C3, 2, 3, 0, 0);
      run_cycle(1, 5, 16'h0FF0, 2, 12, 0, 0);
      run_cycle(0, 6, 16'h7E81, 4, 20, 0, 0);
      run_cycle(1, 1, 16'h3C3C, 0, 30, 0, 0);

      // R6 timeout, then a normal cycle must report no error
      run_cycle(0, 3, 16'hDEAD, 4, 0, 1, 0);
      run_cycle(0, 4, 16'hBEEF, 4, 0, 0, 0);

      // R9 read followed at once by a write in the fastest mode; R12 poke while busy
      run_cycle(0, 7, 16'h8001, 4, 0, 0, 0);
      run_cycle(1, 0, 16'h8002, 4, 0, 0, 1);
      run_cycle(0, 2, 16'h1111, 3, 0, 0, 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule